// File: doc/BRIEF.md
# Binary32 NaN Result Selector

This unit produces the result of a two-input single-precision operation when at least one of the operands is a NaN. It classifies each operand as an ordinary value, a quiet NaN or a signaling NaN, chooses one operand under a priority policy picked at run time, and turns a signaling choice into a quiet NaN. It also raises an invalid-operation flag whenever a signaling NaN is among the inputs. A forced default-NaN mode makes it return the canonical NaN whatever the operands are.

The quiet/signaling meaning of the top fraction bit is set at run time by a polarity input. The result and the flag are registered and come out one clock after the input strobe, with an output strobe alongside. The unit does not define a result when neither operand is a NaN.

Top module: `fnan_select`

## Requirements
- R1: After a synchronous reset, `res_vld`, `res_val` and `res_invalid` are all 0.
- R2: `res_vld` is `in_vld` delayed by exactly one clock. `res_val` and `res_invalid` are loaded only on a clock edge where `in_vld` is 1. While `in_vld` is 0, changes on the other inputs leave them unchanged.
- R3: An operand is a NaN when its exponent bits [30:23] are all ones and its fraction [22:0] is non-zero. With `snan_pol`=0, fraction bit 22 set means quiet and clear means signaling. With `snan_pol`=1, bit 22 set means signaling and clear means quiet. An all-ones exponent with a zero fraction (infinity) is not a NaN.
- R4: `res_invalid` is 1 exactly when at least one operand is a signaling NaN. This holds for every policy and in default-NaN mode.
- R5: With `dnan_mode`=1 the result is the default NaN. This is 0x7FC00000 for `snan_pol`=0 and 0x7FBFFFFF for `snan_pol`=1.
- R6: Policy 0 (`policy`=2'b00), and also the unassigned code 2'b11, selects the first match in this order: A if signaling, B if signaling, A if quiet, otherwise B.
- R7: Policy 1 (`policy`=2'b01) selects A if A is any NaN, otherwise B.
- R8: Policy 2 (`policy`=2'b10) selects as follows. With one signaling and one quiet NaN, it takes the quiet one. With two NaNs of the same kind, it takes the one with the larger significand. With one NaN and one ordinary value, it takes the NaN.
- R9: Under policy 2, A is larger when bits [30:0] of A exceed bits [30:0] of B. When those bits are equal, A is larger when the full 32-bit A is below B, so the operand with the positive sign wins.
- R10: A selected signaling NaN is made quiet before it is output. With `snan_pol`=0 this sets bit 22 and keeps the other bits. With `snan_pol`=1 the default NaN of R5 replaces it. A selected quiet NaN passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands and controls valid this cycle |
| opa | input | 32 | Operand A, binary32 |
| opb | input | 32 | Operand B, binary32 |
| policy | input | 2 | Selection policy code |
| dnan_mode | input | 1 | Force the default NaN result |
| snan_pol | input | 1 | Meaning of fraction bit 22 (0: set = quiet) |
| res_vld | output | 1 | Result valid |
| res_val | output | 32 | Selected and quietened NaN |
| res_invalid | output | 1 | Invalid-operation flag |

## Verification
Every result, flag and strobe of this block is due on the first rising edge after the edge that captures `in_vld`. The bench drives a vector on a falling edge, lets one rising edge pass, and reads `res_val`, `res_invalid` and `res_vld` on the next falling edge, well clear of the sampling edge. For the hold behaviour, the bench idles `in_vld` for two cycles while changing the operands, then reads the outputs again. They must still show the last loaded values, with the strobe low.

// File: rtl/fnan_pkg.sv
package fnan_pkg;
  typedef enum logic [1:0] {
    CLS_NUM  = 2'd0,
    CLS_QNAN = 2'd1,
    CLS_SNAN = 2'd2
  } nan_cls_e;

  typedef enum logic [1:0] {
    PICK_SIG_FIRST = 2'd0,
    PICK_A_FIRST   = 2'd1,
    PICK_LARGER    = 2'd2,
    PICK_SPARE     = 2'd3
  } pick_pol_e;
endpackage

// File: rtl/fnan_classify.sv
module fnan_classify
  import fnan_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int MAG_W = EXP_W + FRAC_W
) (
  input  logic [MAG_W-1:0] mag,
  input  logic             snan_pol,
  output nan_cls_e         cls
);
  logic exp_max;
  logic frac_nz;
  logic top_bit;

  assign exp_max = &mag[MAG_W-1:FRAC_W];
  assign frac_nz = |mag[FRAC_W-1:0];
  assign top_bit = mag[FRAC_W-1];

  always_comb begin
    if (!exp_max || !frac_nz) cls = CLS_NUM;
    else if (top_bit ^ snan_pol) cls = CLS_QNAN;
    else cls = CLS_SNAN;
  end
endmodule

// File: rtl/fnan_order.sv
module fnan_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         a_larger
);
  logic [W-2:0] a_mag;
  logic [W-2:0] b_mag;

  assign a_mag = a[W-2:0];
  assign b_mag = b[W-2:0];

  // magnitude decides; on a tie the smaller full word (positive sign) wins
  assign a_larger = (a_mag > b_mag) || ((a_mag == b_mag) && (a < b));
endmodule

// File: rtl/fnan_pick.sv
module fnan_pick
  import fnan_pkg::*;
(
  input  pick_pol_e policy,
  input  nan_cls_e  cls_a,
  input  nan_cls_e  cls_b,
  input  logic      a_larger,
  output logic      pick_b
);
  always_comb begin
    pick_b = 1'b0;
    unique case (policy)
      PICK_A_FIRST: pick_b = (cls_a == CLS_NUM);
      PICK_LARGER: begin
        if (cls_a == CLS_SNAN) begin
          if (cls_b == CLS_SNAN) pick_b = !a_larger;
          else pick_b = (cls_b == CLS_QNAN);
        end else if (cls_a == CLS_QNAN) begin
          if (cls_b == CLS_QNAN) pick_b = !a_larger;
          else pick_b = 1'b0;
        end else begin
          pick_b = 1'b1;
        end
      end
      default: begin
        if (cls_a == CLS_SNAN) pick_b = 1'b0;
        else if (cls_b == CLS_SNAN) pick_b = 1'b1;
        else if (cls_a == CLS_QNAN) pick_b = 1'b0;
        else pick_b = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/fnan_select.sv
module fnan_select
  import fnan_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [1:0]   policy,
  input  logic         dnan_mode,
  input  logic         snan_pol,
  output logic         res_vld,
  output logic [W-1:0] res_val,
  output logic         res_invalid
);
  localparam int NOPS = 2;

  logic [NOPS-1:0][W-1:0] ops;
  nan_cls_e               cls [NOPS];
  logic                   a_larger;
  logic                   pick_b;
  logic [W-1:0]           chosen;
  nan_cls_e               chosen_cls;
  logic [W-1:0]           dflt_nan;
  logic [W-1:0]           quiet_val;
  logic [W-1:0]           res_next;
  logic                   inv_next;

  assign ops[0] = opa;
  assign ops[1] = opb;

  for (genvar g = 0; g < NOPS; g++) begin : g_cls
    fnan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) cls_i (
      .mag      (ops[g][W-2:0]),
      .snan_pol (snan_pol),
      .cls      (cls[g])
    );
  end

  fnan_order #(.W(W)) order_i (
    .a        (opa),
    .b        (opb),
    .a_larger (a_larger)
  );

  fnan_pick pick_i (
    .policy   (pick_pol_e'(policy)),
    .cls_a    (cls[0]),
    .cls_b    (cls[1]),
    .a_larger (a_larger),
    .pick_b   (pick_b)
  );

  assign chosen     = pick_b ? opb : opa;
  assign chosen_cls = pick_b ? cls[1] : cls[0];

  assign dflt_nan = snan_pol ? {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}}
                             : {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  always_comb begin
    quiet_val = chosen;
    if (snan_pol) quiet_val = dflt_nan;
    else quiet_val[FRAC_W-1] = 1'b1;
  end

  assign res_next = dnan_mode ? dflt_nan
                  : (chosen_cls == CLS_SNAN) ? quiet_val : chosen;
  assign inv_next = (cls[0] == CLS_SNAN) || (cls[1] == CLS_SNAN);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld     <= 1'b0;
      res_val     <= '0;
      res_invalid <= 1'b0;
    end else begin
      res_vld <= in_vld;
      if (in_vld) begin
        res_val     <= res_next;
        res_invalid <= inv_next;
      end
    end
  end
endmodule

// File: rtl/fnan_select_chk.sv
module fnan_select_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst,
  input logic         in_vld,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [1:0]   policy,
  input logic         dnan_mode,
  input logic         snan_pol,
  input logic         res_vld,
  input logic [W-1:0] res_val,
  input logic         res_invalid
);
  logic a_nan, b_nan, a_sig, b_sig, a_qui;

  assign a_nan = (&opa[W-2:FRAC_W]) && (|opa[FRAC_W-1:0]);
  assign b_nan = (&opb[W-2:FRAC_W]) && (|opb[FRAC_W-1:0]);
  assign a_sig = a_nan && (opa[FRAC_W-1] == snan_pol);
  assign b_sig = b_nan && (opb[FRAC_W-1] == snan_pol);
  assign a_qui = a_nan && !a_sig;

  AST_VLD_RISE: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> res_vld); // R2
  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> (!res_vld && $stable(res_val) && $stable(res_invalid))); // R2
  AST_INV_SET: assert property (@(posedge clk) disable iff (rst)
    (in_vld && (a_sig || b_sig)) |=> res_invalid); // R4
  AST_INV_CLR: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !a_sig && !b_sig) |=> !res_invalid); // R4
  AST_DNAN_VAL: assert property (@(posedge clk) disable iff (rst)
    (in_vld && dnan_mode && !snan_pol) |=> (res_val == {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}})); // R5
  AST_A_FIRST: assert property (@(posedge clk) disable iff (rst)
    (in_vld && policy == 2'd1 && !dnan_mode && a_qui) |=> (res_val == $past(opa))); // R7
  AST_QUIET_OUT: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !snan_pol) |=> res_val[FRAC_W-1]); // R10
endmodule

bind fnan_select fnan_select_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (.*);

// File: tb/fnan_select_tb_top.sv
module fnan_select_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_vld;
  logic [31:0] opa, opb;
  logic [1:0]  policy;
  logic        dnan_mode, snan_pol;
  logic        res_vld;
  logic [31:0] res_val;
  logic        res_invalid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fnan_select dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .opa(opa), .opb(opb),
    .policy(policy), .dnan_mode(dnan_mode), .snan_pol(snan_pol),
    .res_vld(res_vld), .res_val(res_val), .res_invalid(res_invalid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp_v);
    end
  endtask

  task automatic run(input string req, input logic [31:0] a, input logic [31:0] b,
                     input logic [1:0] pol, input logic dn, input logic sp,
                     input logic [31:0] exp_r, input logic exp_i);
    @(negedge clk);
    in_vld = 1'b1; opa = a; opb = b; policy = pol; dnan_mode = dn; snan_pol = sp;
    @(negedge clk);
    in_vld = 1'b0;
    chk(req, res_val, exp_r);
    chk(req, {31'd0, res_invalid}, {31'd0, exp_i});
    chk(req, {31'd0, res_vld}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R1", res_val, 32'd0);
    chk("R1", {31'd0, res_vld}, 32'd0);
    chk("R1", {31'd0, res_invalid}, 32'd0);
  endtask

  task automatic t_policy0;
    run("R6", 32'h7F800011, 32'h7F800022, 2'd0, 0, 0, 32'h7FC00011, 1);
    run("R6", 32'h7FC00100, 32'h7F800022, 2'd0, 0, 0, 32'h7FC00022, 1);
    run("R6", 32'h7FC00100, 32'hFFC00200, 2'd0, 0, 0, 32'h7FC00100, 0);
    run("R6", 32'h3F800000, 32'hFFC00200, 2'd0, 0, 0, 32'hFFC00200, 0);
    run("R6_spare", 32'h7FC00100, 32'h7F800022, 2'd3, 0, 0, 32'h7FC00022, 1);
  endtask

  task automatic t_policy1;
    run("R7", 32'h7FC00100, 32'h7F800022, 2'd1, 0, 0, 32'h7FC00100, 1);
    run("R7", 32'h3F800000, 32'h7F800022, 2'd1, 0, 0, 32'h7FC00022, 1);
  endtask

  task automatic t_policy2;
    run("R8", 32'h7F800011, 32'hFFC00200, 2'd2, 0, 0, 32'hFFC00200, 1);
    run("R8", 32'h7FC00100, 32'h7F800022, 2'd2, 0, 0, 32'h7FC00100, 1);
    run("R8", 32'h3F800000, 32'h7F800011, 2'd2, 0, 0, 32'h7FC00011, 1);
    run("R8", 32'h7F800011, 32'h3F800000, 2'd2, 0, 0, 32'h7FC00011, 1);
    run("R9", 32'h7F800011, 32'h7F800022, 2'd2, 0, 0, 32'h7FC00022, 1);
    run("R9", 32'h7FC00100, 32'hFFC00200, 2'd2, 0, 0, 32'hFFC00200, 0);
    run("R9", 32'h7FC00300, 32'hFFC00200, 2'd2, 0, 0, 32'h7FC00300, 0);
    run("R9_tie", 32'h7FC00100, 32'hFFC00100, 2'd2, 0, 0, 32'h7FC00100, 0);
    run("R9_tie", 32'hFFC00100, 32'h7FC00100, 2'd2, 0, 0, 32'h7FC00100, 0);
  endtask

  task automatic t_dnan;
    run("R5", 32'h7F800011, 32'hFFC00200, 2'd0, 1, 0, 32'h7FC00000, 1);
    run("R5", 32'h7FC00100, 32'hFFC00200, 2'd2, 1, 0, 32'h7FC00000, 0);
    run("R5", 32'h7F800020, 32'h3F800000, 2'd1, 1, 1, 32'h7FBFFFFF, 0);
  endtask

  task automatic t_polarity;
    run("R10", 32'h7FC00010, 32'h7F800020, 2'd0, 0, 1, 32'h7FBFFFFF, 1);
    run("R10", 32'h7F800020, 32'h3F800000, 2'd0, 0, 1, 32'h7F800020, 0);
    run("R3", 32'h7FC00000, 32'h7F800020, 2'd1, 0, 1, 32'h7FBFFFFF, 1);
    run("R3_inf", 32'h7F800000, 32'hFFC00200, 2'd1, 0, 0, 32'hFFC00200, 0);
    run("R4", 32'h7FC00100, 32'h7F800020, 2'd1, 0, 0, 32'h7FC00100, 1);
  endtask

  task automatic t_hold;
    run("R2", 32'h7FC00100, 32'hFFC00200, 2'd0, 0, 0, 32'h7FC00100, 0);
    opa = 32'h7F800001; opb = 32'h7F800002; policy = 2'd2;
    @(negedge clk);
    @(negedge clk);
    chk("R2", res_val, 32'h7FC00100);
    chk("R2", {31'd0, res_invalid}, 32'd0);
    chk("R2", {31'd0, res_vld}, 32'd0);
  endtask

  initial begin
    rst = 1'b1; in_vld = 1'b0; opa = '0; opb = '0; policy = '0;
    dnan_mode = 1'b0; snan_pol = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_policy0();
    t_policy1();
    t_policy2();
    t_dnan();
    t_polarity();
    t_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule